// File: doc/BRIEF.md
# Extension-Enable Configuration Register with Return-Address Alignment

This block is a machine-level control register that reports which instruction-set extensions are enabled. When built as writable, it lets software turn them on and off. It sits behind a simple register access port made of an address, write data, a write strobe and combinational read data. It drives one enable flag per extension to the rest of the core.

Every write is legalized before it is stored, and no write ever raises a trap:

- Unimplemented bits are discarded.
- A base selection that names neither the full nor the reduced register file keeps the previous base.
- Extension pairs that cannot coexist are trimmed.

The same block holds the machine exception return address. While compressed instructions are disabled, bit 1 of that address is hidden, so a return always lands on a 4-byte boundary.

A third function checks register indices presented by decode. While the reduced base is active, any index of 16 or above is flagged as illegal.

Top module: `isa_cfg_csr`

## Requirements
- R1: After reset the extension register reads XLEN-code 01 in bits 31:30 together with extensions A (bit 0), C (bit 2), D (bit 3), F (bit 5), I (bit 8) and M (bit 12); E (bit 4) is clear. The return-address register reads zero.
- R2: Bits 31:30 of the extension register always read 01. Bits 29:26 always read zero. Any extension bit outside the implemented set (A, C, D, E, F, I, M) always reads zero, whatever was written.
- R3: A write to address 0x301 (extension register) or 0x341 (return address) takes effect at the next rising clock edge. A read in the same cycle returns the old value.
- R4: When the writable parameter is 0, writes to the extension register are accepted without any trap indication and leave it at its reset value.
- R5: A written value with neither I (bit 8) nor E (bit 4) set keeps the previous I/E setting, while the other extension bits of the write still apply.
- R6: A written value with both I and E set selects I and clears E.
- R7: While E is the stored base, F (bit 5) and D (bit 3) are dropped from the write and read back as zero.
- R8: D without F in the legalized value is dropped, so D reads zero.
- R9: Bit 0 of a value written to the return-address register is stored as zero. While C (bit 2) is clear at the time of the write, bit 1 is stored as zero too.
- R10: While C is clear, reads of the return-address register show bit 1 as zero. A stored bit 1 becomes visible again once C is set.
- R11: `illegal_reg` is high exactly when `rs_valid` is high, E is the stored base, and `rs_idx` is 16 or more.
- R12: The flags `ext_m`, `ext_a`, `ext_f`, `ext_d`, `ext_c` and `ext_e` always equal bits 12, 0, 5, 3, 2 and 4 of the stored extension register.
- R13: Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN (32) | Write data |
| csr_rdata | output | XLEN (32) | Combinational read data |
| rs_valid | input | 1 | Register index from decode is valid |
| rs_idx | input | IDX_W (5) | Register index from decode |
| illegal_reg | output | 1 | Index not available under the reduced base |
| ext_m | output | 1 | Multiply/divide enabled |
| ext_a | output | 1 | Atomics enabled |
| ext_f | output | 1 | Single-precision float enabled |
| ext_d | output | 1 | Double-precision float enabled |
| ext_c | output | 1 | Compressed instructions enabled |
| ext_e | output | 1 | Reduced register file base active |

## Verification
The legalization path is driven with several kinds of write:

- A value with no base bit separates "keep old base" from "take the written base".
- A value with both base bits shows which base has priority.
- A reduced-base value carrying the float bits checks the trimming.
- A lone D exposes the F dependency.
- Values with the read-only and unimplemented bits set show that those bits are masked.

The return-address register is written with odd and 2-byte-aligned values while C toggles. This separates masking at write time from masking at read time.

A randomized stretch mixes addresses, strobes and register indices, so that the writes, the read mux and the index check interact. A second instance built read-only receives the same stimulus to show that writes are discarded without side effects.

// File: rtl/isa_cfg_pkg.sv
package isa_cfg_pkg;

  localparam int EXT_W = 26;

  localparam int EXT_A = 0;
  localparam int EXT_C = 2;
  localparam int EXT_D = 3;
  localparam int EXT_E = 4;
  localparam int EXT_F = 5;
  localparam int EXT_I = 8;
  localparam int EXT_M = 12;

  typedef logic [EXT_W-1:0] ext_t;

  // Turns a requested extension set into a legal one.
  function automatic ext_t legalize_ext(input ext_t cur, input ext_t wr, input ext_t impl);
    ext_t v;
    v = wr & impl;
    if (!v[EXT_I] && !v[EXT_E]) begin
      // No base named: keep the current base selection.
      v[EXT_I] = cur[EXT_I];
      v[EXT_E] = cur[EXT_E];
    end else if (v[EXT_I]) begin
      v[EXT_E] = 1'b0;
    end
    if (v[EXT_E]) begin
      v[EXT_F] = 1'b0;
      v[EXT_D] = 1'b0;
    end
    if (!v[EXT_F]) begin
      v[EXT_D] = 1'b0;
    end
    return v;
  endfunction

  function automatic logic base_missing(input ext_t wr, input ext_t impl);
    ext_t v;
    v = wr & impl;
    return !v[EXT_I] && !v[EXT_E];
  endfunction

endpackage

// File: rtl/isa_ext_reg.sv
module isa_ext_reg
  import isa_cfg_pkg::*;
#(
  parameter ext_t IMPL_MASK = 26'h000113D,
  parameter ext_t RESET_EXT = 26'h000112D,
  parameter bit   WRITABLE  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ext_t wr_ext,
  output ext_t ext_q,
  output logic base_kept
);

  localparam ext_t RST_LEGAL = RESET_EXT & IMPL_MASK;

  generate
    if (WRITABLE) begin : g_rw
      ext_t ext_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_r <= RST_LEGAL;
        else if (wr_en) ext_r <= legalize_ext(ext_r, wr_ext, IMPL_MASK);
      end
      assign ext_q     = ext_r;
      assign base_kept = wr_en && base_missing(wr_ext, IMPL_MASK);
    end else begin : g_ro
      logic unused_ro;
      assign unused_ro = ^{clk, rst_n, wr_en, wr_ext};
      assign ext_q     = RST_LEGAL;
      assign base_kept = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/isa_epc_reg.sv
module isa_epc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            c_on,
  output logic [XLEN-1:0] rd_data
);

  // Bit 0 is never stored; bit 1 only while compressed code is enabled.
  function automatic logic [XLEN-1:0] align_mask(input logic c);
    logic [XLEN-1:0] m;
    m    = '1;
    m[0] = 1'b0;
    m[1] = c;
    return m;
  endfunction

  logic [XLEN-1:0] epc_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) epc_r <= '0;
    else if (wr_en) epc_r <= wr_data & align_mask(c_on);
  end

  assign rd_data = epc_r & align_mask(c_on);

endmodule

// File: rtl/isa_reg_guard.sv
module isa_reg_guard #(
  parameter int IDX_W = 5
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  input  logic             e_on,
  output logic             illegal
);

  localparam int E_REGS = 16;

  assign illegal = valid && e_on && (int'(idx) >= E_REGS);

endmodule

// File: rtl/isa_cfg_csr.sv
module isa_cfg_csr
  import isa_cfg_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          IDX_W     = 5,
  parameter bit          WRITABLE  = 1'b1,
  parameter ext_t        IMPL_MASK = 26'h000113D,
  parameter ext_t        RESET_EXT = 26'h000112D,
  parameter logic [11:0] ADDR_ISA  = 12'h301,
  parameter logic [11:0] ADDR_EPC  = 12'h341
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      csr_addr,
  input  logic             csr_we,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic             rs_valid,
  input  logic [IDX_W-1:0] rs_idx,
  output logic             illegal_reg,
  output logic             ext_m,
  output logic             ext_a,
  output logic             ext_f,
  output logic             ext_d,
  output logic             ext_c,
  output logic             ext_e
);

  localparam logic [1:0] MXL = (XLEN == 32) ? 2'd1 : (XLEN == 64) ? 2'd2 : 2'd3;
  localparam int PAD_W = XLEN - 2 - EXT_W;

  ext_t            ext_q;
  logic            base_kept;
  logic            ext_wr;
  logic            epc_wr;
  logic [XLEN-1:0] epc_rd;
  logic [XLEN-1:0] isa_word;

  assign ext_wr = csr_we && (csr_addr == ADDR_ISA);
  assign epc_wr = csr_we && (csr_addr == ADDR_EPC);

  isa_ext_reg #(
    .IMPL_MASK(IMPL_MASK),
    .RESET_EXT(RESET_EXT),
    .WRITABLE (WRITABLE)
  ) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ext_wr),
    .wr_ext   (csr_wdata[EXT_W-1:0]),
    .ext_q    (ext_q),
    .base_kept(base_kept)
  );

  isa_epc_reg #(.XLEN(XLEN)) u_epc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (epc_wr),
    .wr_data(csr_wdata),
    .c_on   (ext_q[EXT_C]),
    .rd_data(epc_rd)
  );

  isa_reg_guard #(.IDX_W(IDX_W)) u_guard (
    .valid  (rs_valid),
    .idx    (rs_idx),
    .e_on   (ext_q[EXT_E]),
    .illegal(illegal_reg)
  );

  assign isa_word = {MXL, {PAD_W{1'b0}}, ext_q};

  always_comb begin
    if (csr_addr == ADDR_ISA)      csr_rdata = isa_word;
    else if (csr_addr == ADDR_EPC) csr_rdata = epc_rd;
    else                           csr_rdata = '0;
  end

  assign ext_m = ext_q[EXT_M];
  assign ext_a = ext_q[EXT_A];
  assign ext_f = ext_q[EXT_F];
  assign ext_d = ext_q[EXT_D];
  assign ext_c = ext_q[EXT_C];
  assign ext_e = ext_q[EXT_E];

endmodule

// File: rtl/isa_cfg_chk.sv
module isa_cfg_chk
  import isa_cfg_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          IDX_W    = 5,
  parameter bit          WRITABLE = 1'b1,
  parameter logic [11:0] ADDR_ISA = 12'h301,
  parameter logic [11:0] ADDR_EPC = 12'h341
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_we,
  input logic [11:0]      csr_addr,
  input logic [XLEN-1:0]  csr_rdata,
  input logic             rs_valid,
  input logic [IDX_W-1:0] rs_idx,
  input logic             illegal_reg,
  input ext_t             ext_q,
  input logic             base_kept
);

  // R2
  mxl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_ISA) |-> (csr_rdata[XLEN-1 -: 6] == 6'b010000));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable(ext_q));

  // R5
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_kept |=> (ext_q[EXT_I] == $past(ext_q[EXT_I])) && (ext_q[EXT_E] == $past(ext_q[EXT_E])));

  // R6
  one_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ext_q[EXT_I], ext_q[EXT_E]}) == 1);

  // R7
  e_no_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[EXT_E] |-> (!ext_q[EXT_F] && !ext_q[EXT_D]));

  // R8
  d_needs_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[EXT_D] |-> ext_q[EXT_F]);

  // R10
  epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_addr == ADDR_EPC) && !ext_q[EXT_C]) |-> (csr_rdata[1:0] == 2'b00));

  // R11
  reg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && ext_q[EXT_E] && rs_idx[IDX_W-1]) |-> illegal_reg);

  // R11
  reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_valid || !ext_q[EXT_E]) |-> !illegal_reg);

  generate
    if (!WRITABLE) begin : g_ro
      // R4
      ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> $stable(ext_q));
    end
  endgenerate

endmodule

bind isa_cfg_csr isa_cfg_chk #(
  .XLEN    (XLEN),
  .IDX_W   (IDX_W),
  .WRITABLE(WRITABLE),
  .ADDR_ISA(ADDR_ISA),
  .ADDR_EPC(ADDR_EPC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_we     (csr_we),
  .csr_addr   (csr_addr),
  .csr_rdata  (csr_rdata),
  .rs_valid   (rs_valid),
  .rs_idx     (rs_idx),
  .illegal_reg(illegal_reg),
  .ext_q      (ext_q),
  .base_kept  (base_kept)
);

// File: tb/sim_isa_cfg_csr.sv
`timescale 1ns/1ps
module sim_isa_cfg_csr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = 32'h0;
  logic        rs_valid = 1'b0;
  logic [4:0]  rs_idx = 5'd0;

  logic [31:0] rd0, rd1;
  logic        ill0, ill1;
  logic        m0, a0, f0, d0, c0, e0;
  logic        m1, a1, f1, d1, c1, e1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  isa_cfg_csr u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(rd0), .rs_valid(rs_valid), .rs_idx(rs_idx),
    .illegal_reg(ill0), .ext_m(m0), .ext_a(a0), .ext_f(f0), .ext_d(d0),
    .ext_c(c0), .ext_e(e0)
  );

  isa_cfg_csr #(.WRITABLE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(rd1), .rs_valid(rs_valid), .rs_idx(rs_idx),
    .illegal_reg(ill1), .ext_m(m1), .ext_a(a1), .ext_f(f1), .ext_d(d1),
    .ext_c(c1), .ext_e(e1)
  );

  // Reference model state
  logic [25:0] mdl_ext;
  logic [31:0] mdl_epc;
  logic [31:0] mdl_epc1;
  localparam logic [25:0] IMPL = 26'h000113D;
  localparam logic [25:0] RST  = 26'h000112D;

  function automatic int bp(input byte ch);
    return int'(ch) - 65;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] adr, input logic [25:0] ex,
                                           input logic [31:0] ep);
    if (adr == 12'h301) return {2'b01, 4'b0000, ex};
    if (adr == 12'h341) return ex[bp("C")] ? ep : (ep & 32'hFFFF_FFFD);
    return 32'h0;
  endfunction

  function automatic logic [25:0] exp_write(input logic [25:0] old, input logic [31:0] wd);
    logic [25:0] r;
    r = wd[25:0] & IMPL;
    if (r[bp("I")] == 1'b0 && r[bp("E")] == 1'b0) begin
      r[bp("I")] = old[bp("I")];
      r[bp("E")] = old[bp("E")];
    end
    if (r[bp("I")]) r[bp("E")] = 1'b0;
    if (r[bp("E")]) begin
      r[bp("F")] = 1'b0;
      r[bp("D")] = 1'b0;
    end
    if (!r[bp("F")]) r[bp("D")] = 1'b0;
    return r;
  endfunction

  function automatic logic [5:0] flags(input logic [25:0] ex);
    return {ex[bp("M")], ex[bp("A")], ex[bp("F")], ex[bp("D")], ex[bp("C")], ex[bp("E")]};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare 1 ns later, advance the model at the rising edge.
  task automatic step(input string req, input logic [11:0] adr, input logic we,
                      input logic [31:0] wd, input logic v, input logic [4:0] idx);
    logic exp_ill;
    @(negedge clk);
    csr_addr  = adr;
    csr_we    = we;
    csr_wdata = wd;
    rs_valid  = v;
    rs_idx    = idx;
    #1;
    exp_ill = v && mdl_ext[bp("E")] && (idx >= 5'd16);
    check(req, "u0 rdata/flags/illegal", {25'd0, rd0, m0, a0, f0, d0, c0, e0, ill0},
          {25'd0, exp_read(adr, mdl_ext, mdl_epc), flags(mdl_ext), exp_ill});
    check("R4", "u1 read-only", {25'd0, rd1, m1, a1, f1, d1, c1, e1, ill1},
          {25'd0, exp_read(adr, RST, mdl_epc1), flags(RST), 1'b0});
    @(posedge clk);
    if (we && adr == 12'h301) mdl_ext = exp_write(mdl_ext, wd);
    if (we && adr == 12'h341) begin
      mdl_epc  = wd & (mdl_ext[bp("C")] ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
      mdl_epc1 = wd & 32'hFFFF_FFFE;
    end
  endtask

  task automatic rd(input string req, input logic [11:0] adr);
    step(req, adr, 1'b0, 32'h0, 1'b0, 5'd0);
  endtask

  task automatic wr(input string req, input logic [11:0] adr, input logic [31:0] wd);
    step(req, adr, 1'b1, wd, 1'b0, 5'd0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    mdl_ext  = RST;
    mdl_epc  = 32'h0;
    mdl_epc1 = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1", 12'h301);
    rd("R1", 12'h341);
    // R13 unmapped address
    rd("R13", 12'h300);
    wr("R13", 12'h300, 32'hFFFF_FFFF);
    rd("R13", 12'h301);
    // R3: the write cycle itself shows the old value
    wr("R3", 12'h301, 32'h0000_0100);
    rd("R3", 12'h301);
    // R5 no base named: base kept, rest applied
    wr("R5", 12'h301, 32'h0000_1001);
    rd("R5", 12'h301);
    wr("R5", 12'h301, 32'h0);
    rd("R12", 12'h301);
    // R6 both bases
    wr("R6", 12'h301, 32'h0000_1114);
    rd("R6", 12'h301);
    // R7 reduced base drops float
    wr("R7", 12'h301, 32'h0000_1039);
    rd("R7", 12'h301);
    // R11 register index guard under E
    step("R11", 12'h301, 1'b0, 32'h0, 1'b1, 5'd16);
    step("R11", 12'h301, 1'b0, 32'h0, 1'b1, 5'd15);
    step("R11", 12'h301, 1'b0, 32'h0, 1'b1, 5'd31);
    step("R11", 12'h301, 1'b0, 32'h0, 1'b0, 5'd20);
    // R5 no base while E active keeps E
    wr("R5", 12'h301, 32'h0000_0020);
    rd("R5", 12'h301);
    // R8 D without F
    wr("R8", 12'h301, 32'h0000_0108);
    rd("R8", 12'h301);
    // R2 read-only and unimplemented bits
    wr("R2", 12'h301, 32'hFFFF_FFFF);
    rd("R2", 12'h301);
    // R9 alignment on write with C set
    wr("R9", 12'h341, 32'h0000_1007);
    rd("R9", 12'h341);
    // R10 clear C: bit 1 hidden, then visible again
    wr("R10", 12'h301, 32'h0000_0100);
    rd("R10", 12'h341);
    wr("R10", 12'h301, 32'h0000_0104);
    rd("R10", 12'h341);
    // R9 write with C clear drops bit 1 for good
    wr("R9", 12'h301, 32'h0000_0100);
    wr("R9", 12'h341, 32'h0000_2003);
    wr("R9", 12'h301, 32'h0000_0104);
    rd("R9", 12'h341);

    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = 12'h301;
        1: a = 12'h341;
        2: a = 12'h301;
        default: a = 12'h7C0;
      endcase
      step("R12", a, 1'($urandom_range(0, 1)), $urandom(), 1'($urandom_range(0, 1)),
           5'($urandom_range(0, 31)));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule